// File: doc/BRIEF.md
# Per-Thread Reorder Buffer Partition Allocator

This block keeps track of the reorder buffer of a core that runs several hardware threads at once. The buffer holds `NUM_PART` contiguous partitions of `PART_SIZE` entries each. A partition is only ever owned by one thread at a time, so each thread can allocate, retire and flush its own entries without touching the order of any other thread. Each thread keeps its own partitions as a chain from oldest to youngest. Its head pointer (the oldest entry) and its tail pointer (the next free slot) move from one partition to the next along that chain.

The `dyn_mode` input picks the sharing policy. It is sampled during reset and must stay constant afterwards. In the fixed policy (`dyn_mode`=0), thread t may only use the slice of partitions t*(NUM_PART/NUM_THR) to (t+1)*(NUM_PART/NUM_THR)-1. In the shared policy (`dyn_mode`=1), a thread that needs more room takes any free partition. A partition goes back to the pool as soon as everything in it has retired. A thread always keeps at least the partition it is currently filling. The block tracks only entry indices, ownership and order. Instruction contents are handled elsewhere.

Top module: `rob_part_alloc`

## Requirements
- R1: After reset every thread is empty and owns exactly one partition. In the fixed policy this is partition t*(NUM_PART/NUM_THR); in the shared policy it is partition t. The head index of thread t is that partition times PART_SIZE, and `part_free` is set for every other partition.
- R2: An allocation request that fits in the current tail partition is granted in the same cycle. The entry index is partition*PART_SIZE+offset, and offsets rise by one per grant.
- R3: A request that arrives when the tail partition is full takes the lowest-numbered eligible free partition in the same cycle. The granted index is that partition*PART_SIZE, and the partition is chained after the previous tail.
- R4: In the fixed policy a thread only ever receives partitions from its own slice.
- R5: In the shared policy any free partition may go to any thread, and a thread always keeps at least one partition.
- R6: A request is refused (grant low) when the tail partition is full and no eligible free partition is left.
- R7: A commit retires the entry at the head, and the head index then follows the thread's chain in allocation order. A commit to an empty thread has no effect. Commits on one thread never change another thread's state.
- R8: A partition that has been fully retired returns to the free pool (its `part_free` bit is set) on the next cycle. If a thread becomes completely empty, its pointers rewind to offset 0 of the partition it keeps.
- R9: A squash empties only the squashed thread. That thread keeps its head partition with offsets rewound, and all its other partitions become free. Its allocation and commit inputs are ignored in that cycle.
- R10: When more threads need a fresh partition in one cycle than there are free ones, the threads are served in rotating order. Priority starts after the first thread that won a partition last time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dyn_mode | input | 1 | 0 = fixed per-thread slices, 1 = shared pool |
| alloc_req | input | NUM_THR | Per-thread request for one entry |
| alloc_gnt | output | NUM_THR | Per-thread grant, same cycle |
| alloc_idx | output | NUM_THR*IW | Granted entry index per thread |
| commit_req | input | NUM_THR | Retire the head entry of the thread |
| squash_req | input | NUM_THR | Flush all entries of the thread |
| head_idx | output | NUM_THR*IW | Index of the oldest entry per thread |
| occupancy | output | NUM_THR*CW | Entries in flight per thread |
| part_free | output | NUM_PART | Free flag per partition |

## Verification
Grants and granted indices are combinational, so the bench checks them about 2 ns after it drives a request, in the same cycle. Head index, occupancy and the free flags are registered, so they show the effect of a request one clock edge later. The bench compares them in the next cycle, after its reference model has applied that edge. Because of this, a released partition is reported free, and is eligible for a new grant, only from the cycle after the commit that drained it. The model mirrors this timing.

// File: rtl/rob_part_pkg.sv
// Shared definitions for the partition allocator.
// Assumes: nothing beyond the policy encoding below.
package rob_part_pkg;
    typedef enum logic {
        POL_FIXED  = 1'b0,
        POL_SHARED = 1'b1
    } part_policy_e;
endpackage

// File: rtl/rob_part_picker.sv
// Hands free partitions to threads that need one this cycle.
// Threads are visited in rotating order starting at rr_ptr; each takes the
// lowest-numbered eligible partition not already taken by an earlier thread.
// Assumes: elig already excludes busy partitions.
module rob_part_picker #(
    parameter int T  = 2,
    parameter int P  = 4,
    parameter int PW = 2,
    parameter int TW = 1
) (
    input  logic [T-1:0]         need,
    input  logic [T-1:0][P-1:0]  elig,
    input  logic [TW-1:0]        rr_ptr,
    output logic [T-1:0]         got,
    output logic [T-1:0][PW-1:0] pick,
    output logic                 any_got,
    output logic [TW-1:0]        rr_next
);
    logic [P-1:0] taken;

    // Rotating-priority assignment of free partitions
    always_comb begin
        taken   = '0;
        got     = '0;
        pick    = '0;
        any_got = 1'b0;
        rr_next = rr_ptr;
        for (int k = 0; k < T; k++) begin
            int t;
            t = (int'(rr_ptr) + k) % T;
            if (need[t]) begin
                for (int p = 0; p < P; p++) begin
                    if (!got[t] && elig[t][p] && !taken[p]) begin
                        got[t]   = 1'b1;
                        pick[t]  = PW'(p);
                        taken[p] = 1'b1;
                    end
                end
                if (got[t] && !any_got) begin
                    any_got = 1'b1;
                    rr_next = TW'((t + 1) % T);
                end
            end
        end
    end
endmodule

// File: rtl/rob_thread_ctx.sv
// Head/tail pointer state for one thread's chain of partitions.
// Assumes: new_part is valid whenever new_ok is high; head_next is the
// successor of head_part in this thread's chain.
module rob_thread_ctx #(
    parameter int P  = 4,
    parameter int S  = 4,
    parameter int PW = 2,
    parameter int OW = 3,
    parameter int CW = 5,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] init_part,
    input  logic          alloc_req,
    input  logic          commit_req,
    input  logic          squash_req,
    input  logic          new_ok,
    input  logic [PW-1:0] new_part,
    input  logic [PW-1:0] head_next,
    output logic          need,
    output logic          gnt,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] head_idx,
    output logic [CW-1:0] count,
    output logic [PW-1:0] head_part,
    output logic [PW-1:0] tail_part,
    output logic          rel_vld
);
    logic [OW-1:0] head_off, tail_off, head_off_inc;
    logic [CW-1:0] count_n;
    logic          room, do_cmt;

    // Grant, retire and release decisions for this cycle
    always_comb begin
        room         = (int'(tail_off) < S);
        need         = alloc_req && !squash_req && !room;
        gnt          = alloc_req && !squash_req && (room || new_ok);
        idx          = room ? IW'(int'(tail_part) * S + int'(tail_off))
                            : IW'(int'(new_part) * S);
        do_cmt       = commit_req && !squash_req && (count != '0);
        count_n      = count + CW'(gnt) - CW'(do_cmt);
        head_off_inc = head_off + OW'(do_cmt);
        rel_vld      = !squash_req && (count_n != '0) && (int'(head_off_inc) == S);
        head_idx     = IW'(int'(head_part) * S + int'(head_off));
    end

    // Pointer and occupancy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_part <= init_part;
            tail_part <= init_part;
            head_off  <= '0;
            tail_off  <= '0;
            count     <= '0;
        end else if (squash_req) begin
            tail_part <= head_part;
            head_off  <= '0;
            tail_off  <= '0;
            count     <= '0;
        end else begin
            count <= count_n;
            if (gnt) begin
                if (room) begin
                    tail_off <= tail_off + OW'(1);
                end else begin
                    tail_part <= new_part;
                    tail_off  <= OW'(1);
                end
            end
            if (count_n == '0) begin
                head_off <= '0;
                tail_off <= '0;
            end else if (rel_vld) begin
                head_off  <= '0;
                head_part <= (head_part == tail_part) ? new_part : head_next;
            end else begin
                head_off <= head_off_inc;
            end
        end
    end
endmodule

// File: rtl/rob_part_alloc.sv
// Reorder buffer partition allocator for NUM_THR threads.
// Holds the partition table (busy, owner, successor) and wires up one
// pointer context per thread plus the shared partition picker.
// Assumes: NUM_PART is a multiple of NUM_THR and NUM_PART >= NUM_THR;
// dyn_mode is held constant from reset onward.
module rob_part_alloc #(
    parameter int NUM_THR   = 2,
    parameter int NUM_PART  = 4,
    parameter int PART_SIZE = 4,
    localparam int PW  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
    localparam int TW  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    localparam int OW  = $clog2(PART_SIZE + 1),
    localparam int CW  = $clog2(NUM_PART * PART_SIZE + 1),
    localparam int IW  = $clog2(NUM_PART * PART_SIZE),
    localparam int PPT = NUM_PART / NUM_THR
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dyn_mode,
    input  logic [NUM_THR-1:0]     alloc_req,
    output logic [NUM_THR-1:0]     alloc_gnt,
    output logic [NUM_THR*IW-1:0]  alloc_idx,
    input  logic [NUM_THR-1:0]     commit_req,
    input  logic [NUM_THR-1:0]     squash_req,
    output logic [NUM_THR*IW-1:0]  head_idx,
    output logic [NUM_THR*CW-1:0]  occupancy,
    output logic [NUM_PART-1:0]    part_free
);
    import rob_part_pkg::*;

    logic [NUM_PART-1:0]                busy;
    logic [NUM_PART-1:0][TW-1:0]        owner;
    logic [NUM_PART-1:0][PW-1:0]        nxt;
    logic [NUM_THR-1:0][NUM_PART-1:0]   elig;
    logic [NUM_THR-1:0]                 need, got, rel_vld;
    logic [NUM_THR-1:0][PW-1:0]         pick, head_part, tail_part, init_part;
    logic [TW-1:0]                      rr_ptr, rr_next;
    logic                               any_got;
    part_policy_e                       policy;

    assign policy    = part_policy_e'(dyn_mode);
    assign part_free = ~busy;

    // Which free partitions each thread may take under the current policy
    always_comb begin
        for (int t = 0; t < NUM_THR; t++) begin
            init_part[t] = (policy == POL_SHARED) ? PW'(t) : PW'(t * PPT);
            for (int p = 0; p < NUM_PART; p++) begin
                elig[t][p] = !busy[p] && ((policy == POL_SHARED) || (p / PPT == t));
            end
        end
    end

    rob_part_picker #(.T(NUM_THR), .P(NUM_PART), .PW(PW), .TW(TW)) u_picker (
        .need    (need),
        .elig    (elig),
        .rr_ptr  (rr_ptr),
        .got     (got),
        .pick    (pick),
        .any_got (any_got),
        .rr_next (rr_next)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        rob_thread_ctx #(
            .P(NUM_PART), .S(PART_SIZE), .PW(PW), .OW(OW), .CW(CW), .IW(IW)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .init_part  (init_part[t]),
            .alloc_req  (alloc_req[t]),
            .commit_req (commit_req[t]),
            .squash_req (squash_req[t]),
            .new_ok     (got[t]),
            .new_part   (pick[t]),
            .head_next  (nxt[head_part[t]]),
            .need       (need[t]),
            .gnt        (alloc_gnt[t]),
            .idx        (alloc_idx[t*IW +: IW]),
            .head_idx   (head_idx[t*IW +: IW]),
            .count      (occupancy[t*CW +: CW]),
            .head_part  (head_part[t]),
            .tail_part  (tail_part[t]),
            .rel_vld    (rel_vld[t])
        );
    end

    // Partition table: ownership, chaining and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
            nxt    <= '0;
            for (int p = 0; p < NUM_PART; p++) begin
                busy[p]  <= dyn_mode ? (p < NUM_THR) : (p % PPT == 0);
                owner[p] <= dyn_mode ? TW'(p % NUM_THR) : TW'(p / PPT);
            end
        end else begin
            if (any_got) rr_ptr <= rr_next;
            for (int t = 0; t < NUM_THR; t++) begin
                if (got[t]) begin
                    busy[pick[t]]      <= 1'b1;
                    owner[pick[t]]     <= TW'(t);
                    nxt[tail_part[t]]  <= pick[t];
                end
                if (rel_vld[t]) busy[head_part[t]] <= 1'b0;
                if (squash_req[t]) begin
                    for (int p = 0; p < NUM_PART; p++) begin
                        if (busy[p] && owner[p] == TW'(t) && PW'(p) != head_part[t])
                            busy[p] <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rob_part_alloc_chk.sv
// Property checker for rob_part_alloc, attached with bind below.
// Assumes: same parameters as the bound instance.
module rob_part_alloc_chk #(
    parameter int NUM_THR   = 2,
    parameter int NUM_PART  = 4,
    parameter int PART_SIZE = 4,
    localparam int CW  = $clog2(NUM_PART * PART_SIZE + 1),
    localparam int IW  = $clog2(NUM_PART * PART_SIZE),
    localparam int PPT = NUM_PART / NUM_THR
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dyn_mode,
    input logic [NUM_THR-1:0]    alloc_req,
    input logic [NUM_THR-1:0]    alloc_gnt,
    input logic [NUM_THR*IW-1:0] alloc_idx,
    input logic [NUM_THR-1:0]    commit_req,
    input logic [NUM_THR-1:0]    squash_req,
    input logic [NUM_THR*CW-1:0] occupancy
);
    for (genvar t = 0; t < NUM_THR; t++) begin : g_a
        AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[t] |-> (alloc_req[t] && !squash_req[t])); // R2
        AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            squash_req[t] |=> (occupancy[t*CW +: CW] == '0)); // R9
        AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !squash_req[t] |=> (int'(occupancy[t*CW +: CW]) ==
                int'($past(occupancy[t*CW +: CW])) + int'($past(alloc_gnt[t]))
                - int'($past(commit_req[t]) && ($past(occupancy[t*CW +: CW]) != '0)))); // R7
        AST_FIXED_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_gnt[t] && !dyn_mode) |->
                (int'(alloc_idx[t*IW +: IW]) / (PART_SIZE * PPT) == t)); // R4
        AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            int'(occupancy[t*CW +: CW]) <= NUM_PART * PART_SIZE); // R6
        for (genvar u = t + 1; u < NUM_THR; u++) begin : g_pair
            AST_NO_SHARED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
                (alloc_gnt[t] && alloc_gnt[u]) |->
                    (alloc_idx[t*IW +: IW] != alloc_idx[u*IW +: IW])); // R5
        end
    end
endmodule

bind rob_part_alloc rob_part_alloc_chk #(
    .NUM_THR(NUM_THR), .NUM_PART(NUM_PART), .PART_SIZE(PART_SIZE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .alloc_req(alloc_req),
    .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx), .commit_req(commit_req),
    .squash_req(squash_req), .occupancy(occupancy)
);

// File: tb/rob_part_alloc_test.sv
// Bench for rob_part_alloc: a behavioural queue model, compared every cycle.
module rob_part_alloc_test;
    localparam int T   = 2;
    localparam int P   = 4;
    localparam int S   = 4;
    localparam int IW  = $clog2(P * S);
    localparam int CW  = $clog2(P * S + 1);
    localparam int PPT = P / T;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dyn_mode = 1'b0;
    logic [T-1:0]      alloc_req = '0, commit_req = '0, squash_req = '0;
    logic [T-1:0]      alloc_gnt;
    logic [T*IW-1:0]   alloc_idx, head_idx;
    logic [T*CW-1:0]   occupancy;
    logic [P-1:0]      part_free;

    rob_part_alloc #(.NUM_THR(T), .NUM_PART(P), .PART_SIZE(S)) uut (
        .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
        .commit_req(commit_req), .squash_req(squash_req),
        .head_idx(head_idx), .occupancy(occupancy), .part_free(part_free)
    );

    always #4 clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    string tag = "R1";

    // reference model
    int m_parts[T][$];
    int m_hoff[T], m_toff[T], m_cnt[T];
    bit m_busy[P];
    int m_rr;
    bit e_gnt[T];
    int e_idx[T], e_pick[T];
    bit e_got[T];

    task automatic chk(input string what, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset(input bit dyn);
        m_rr = 0;
        for (int p = 0; p < P; p++) m_busy[p] = 1'b0;
        for (int t = 0; t < T; t++) begin
            int p0;
            p0 = dyn ? t : t * PPT;
            m_parts[t].delete();
            m_parts[t].push_back(p0);
            m_busy[p0] = 1'b1;
            m_hoff[t] = 0; m_toff[t] = 0; m_cnt[t] = 0;
        end
    endtask

    task automatic predict(input logic [T-1:0] a, input logic [T-1:0] s);
        bit taken[P];
        bit first;
        int rr_n;
        for (int p = 0; p < P; p++) taken[p] = 1'b0;
        first = 1'b1;
        rr_n = m_rr;
        for (int t = 0; t < T; t++) begin e_got[t] = 1'b0; e_pick[t] = 0; end
        for (int k = 0; k < T; k++) begin
            int t;
            t = (m_rr + k) % T;
            if (a[t] && !s[t] && m_toff[t] == S) begin
                for (int p = 0; p < P; p++) begin
                    if (!e_got[t] && !m_busy[p] && !taken[p] && (dyn_mode || p / PPT == t)) begin
                        e_got[t] = 1'b1; e_pick[t] = p; taken[p] = 1'b1;
                    end
                end
                if (e_got[t] && first) begin first = 1'b0; rr_n = (t + 1) % T; end
            end
        end
        for (int t = 0; t < T; t++) begin
            e_gnt[t] = a[t] && !s[t] && (m_toff[t] < S || e_got[t]);
            e_idx[t] = (m_toff[t] < S) ? m_parts[t][$] * S + m_toff[t] : e_pick[t] * S;
        end
        m_rr = rr_n;
    endtask

    task automatic apply(input logic [T-1:0] c, input logic [T-1:0] s);
        for (int t = 0; t < T; t++) begin
            if (s[t]) begin
                while (m_parts[t].size() > 1) m_busy[m_parts[t].pop_back()] = 1'b0;
                m_hoff[t] = 0; m_toff[t] = 0; m_cnt[t] = 0;
            end else begin
                bit cm;
                cm = c[t] && m_cnt[t] > 0;
                if (e_gnt[t]) begin
                    if (m_toff[t] < S) m_toff[t]++;
                    else begin
                        m_parts[t].push_back(e_pick[t]);
                        m_busy[e_pick[t]] = 1'b1;
                        m_toff[t] = 1;
                    end
                end
                m_cnt[t] = m_cnt[t] + int'(e_gnt[t]) - int'(cm);
                m_hoff[t] = m_hoff[t] + int'(cm);
                if (m_cnt[t] == 0) begin
                    m_hoff[t] = 0; m_toff[t] = 0;
                end else if (m_hoff[t] == S) begin
                    m_busy[m_parts[t].pop_front()] = 1'b0;
                    m_hoff[t] = 0;
                end
            end
        end
    endtask

    // One cycle: drive, compare combinational and registered outputs, clock
    task automatic cycle(input logic [T-1:0] a, input logic [T-1:0] c, input logic [T-1:0] s);
        alloc_req = a; commit_req = c; squash_req = s;
        #2;
        predict(a, s);
        for (int t = 0; t < T; t++) begin
            chk($sformatf("gnt[%0d]", t), int'(alloc_gnt[t]), int'(e_gnt[t]));
            if (e_gnt[t]) chk($sformatf("alloc_idx[%0d]", t), int'(alloc_idx[t*IW +: IW]), e_idx[t]);
            chk($sformatf("head_idx[%0d]", t), int'(head_idx[t*IW +: IW]), m_parts[t][0] * S + m_hoff[t]);
            chk($sformatf("occupancy[%0d]", t), int'(occupancy[t*CW +: CW]), m_cnt[t]);
        end
        for (int p = 0; p < P; p++) chk($sformatf("part_free[%0d]", p), int'(part_free[p]), int'(!m_busy[p]));
        @(posedge clk);
        #1;
        apply(c, s);
    endtask

    task automatic do_reset(input bit dyn);
        rst_n = 1'b0; dyn_mode = dyn;
        alloc_req = '0; commit_req = '0; squash_req = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset(dyn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired during %s", tag);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // fixed policy
        do_reset(1'b0);
        tag = "R1"; cycle(2'b00, 2'b00, 2'b00);
        tag = "R2"; repeat (4) cycle(2'b01, 2'b00, 2'b00);
        tag = "R3"; cycle(2'b01, 2'b00, 2'b00);
        tag = "R4"; repeat (3) cycle(2'b01, 2'b00, 2'b00);
        tag = "R6"; repeat (2) cycle(2'b01, 2'b00, 2'b00);
        tag = "R7"; repeat (3) cycle(2'b10, 2'b01, 2'b00);
        cycle(2'b00, 2'b10, 2'b00);
        tag = "R8"; repeat (3) cycle(2'b00, 2'b01, 2'b00);
        tag = "R9"; cycle(2'b11, 2'b01, 2'b01);
        cycle(2'b01, 2'b00, 2'b00);
        tag = "R7";
        for (int i = 0; i < 400; i++)
            cycle(T'($urandom_range(0, 3)), T'($urandom_range(0, 3)),
                  ($urandom_range(0, 40) == 0) ? T'($urandom_range(1, 3)) : '0);

        // shared policy
        do_reset(1'b1);
        tag = "R1"; cycle(2'b00, 2'b00, 2'b00);
        tag = "R5"; repeat (12) cycle(2'b01, 2'b00, 2'b00);
        tag = "R6"; repeat (2) cycle(2'b01, 2'b00, 2'b00);
        tag = "R5"; repeat (6) cycle(2'b10, 2'b00, 2'b00);
        tag = "R8"; repeat (4) cycle(2'b00, 2'b01, 2'b00);
        tag = "R10"; cycle(2'b11, 2'b00, 2'b00);
        repeat (4) cycle(2'b00, 2'b01, 2'b00);
        cycle(2'b11, 2'b00, 2'b00);
        repeat (3) cycle(2'b11, 2'b00, 2'b00);
        tag = "R9"; cycle(2'b11, 2'b11, 2'b10);
        tag = "R3";
        for (int i = 0; i < 3000; i++)
            cycle(T'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0) ? T'($urandom_range(0, 3)) : '0,
                  ($urandom_range(0, 60) == 0) ? T'($urandom_range(1, 3)) : '0);
        tag = "R10";
        for (int i = 0; i < 1000; i++)
            cycle(2'b11, ($urandom_range(0, 1) == 0) ? T'($urandom_range(0, 3)) : '0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule